// File: doc/BRIEF.md
# Lane-Partitioned Integer Add/Subtract Unit

This unit adds or subtracts two 64-bit register words. A run-time size code splits the word into 8-, 16-, 32- or 64-bit lanes, and the carry chain is cut at every lane boundary. In packed mode every lane is an independent operation. In scalar mode only the lowest lane of the chosen size is computed, and every bit above that lane is cleared. Wider datapaths place several copies of this unit side by side, so no lane ever crosses a 64-bit slice.

The unit keeps no status flag. When the operation asks for a second result, the carry (for add) or borrow (for subtract) out of each lane is returned as a second data word, the carry word. That word is addressed to a second destination register whose index is the primary index with its lowest bit flipped. All outputs are registered and appear one clock after the operands, marked by a valid strobe.

Top module: `lane_addsub`

## Requirements
- R1: `size_code` picks the lane width: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits and 3 means 64 bits.
- R2: With `packed_mode` = 1 and `sub` = 0, each lane of `result` equals the sum of the matching lanes of `op_a` and `op_b`, modulo 2^width. No carry passes into the next lane.
- R3: With `packed_mode` = 0, the lowest lane of `result` holds that lane's sum or difference, and every bit of `result` above that lane is 0.
- R4: With `sub` = 1, each computed lane of `result` equals the `op_a` lane minus the `op_b` lane, modulo 2^width. No borrow passes into the next lane.
- R5: With `dual_write` = 1 and `packed_mode` = 1, the least significant bit of each lane of `carry_word` holds that lane's carry-out (add), or a 1 when the unsigned `op_a` lane is smaller than the `op_b` lane (subtract). Every other bit of `carry_word` is 0.
- R6: With `dual_write` = 1 and `packed_mode` = 0, bit 0 of `carry_word` holds the carry or borrow of the lowest lane, and all other bits of `carry_word` are 0.
- R7: With `dual_write` = 0, `carry_word` is 0 and `out_dual` is 0. With `dual_write` = 1, `out_dual` is 1.
- R8: `out_dest` repeats the presented `dest_idx`. `out_dest2` equals `dest_idx` with bit 0 inverted.
- R9: `out_valid` is 1 in the cycle after `in_valid` was sampled high and 0 after it was sampled low. Results are updated only on a sampled `in_valid`.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands presented this cycle |
| op_a | input | 64 | First source word |
| op_b | input | 64 | Second source word (subtrahend) |
| sub | input | 1 | 0 = add, 1 = subtract |
| packed_mode | input | 1 | 1 = all lanes, 0 = lowest lane only |
| size_code | input | 2 | Lane width code (R1) |
| dual_write | input | 1 | Request the carry word as a second result |
| dest_idx | input | 6 | Primary destination register index |
| out_valid | output | 1 | Registered results valid |
| result | output | 64 | Primary result word |
| carry_word | output | 64 | Per-lane carry/borrow word |
| out_dual | output | 1 | Second result is to be written |
| out_dest | output | 6 | Primary destination index |
| out_dest2 | output | 6 | Second destination index |

## Verification
The sum and the carry word come out of the same chain in the same cycle. A lane boundary is therefore the case where both can fail together: a carry that leaks into the next lane corrupts that lane's sum, and it also moves the flag to the wrong bit. The bench sweeps all 32 combinations of size, mode, operation and dual-write with operands built to generate a carry or borrow at every byte boundary, such as all-ones plus one, 0x80 per byte, and equal or reversed operands, along with pseudo-random words. It judges the result word and the carry word of each operation against a lane-by-lane model, back to back, with no idle cycle between operations.

// File: rtl/lane_addsub_pkg.sv
// Package: shared lane-size encoding and helpers for the lane add/subtract unit.
// Assumes the granule (smallest lane) is one byte and the size code is 2 bits.
package lane_addsub_pkg;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_size_e;

    // Number of granules (bytes) making up one lane of the given size.
    function automatic int lane_granules(input logic [1:0] code);
        return int'(1) << code;
    endfunction

endpackage

// File: rtl/lane_addsub_map.sv
// Module: lane_addsub_map
// Decodes the size code and mode bit into per-granule control: where a lane
// starts, where it ends, and whether the granule belongs to a computed lane.
// Assumes NGRAN is a power of two no smaller than the largest lane (8 granules).
module lane_addsub_map
    import lane_addsub_pkg::*;
#(
    parameter int NGRAN = 8
) (
    input  logic [1:0]       size_code,
    input  logic             packed_mode,
    output logic [NGRAN-1:0] gran_first,
    output logic [NGRAN-1:0] gran_last,
    output logic [NGRAN-1:0] gran_live
);

    // Mark lane boundaries and live granules for the selected size and mode.
    always_comb begin
        int span;
        span = lane_granules(size_code);
        for (int i = 0; i < NGRAN; i++) begin
            gran_first[i] = ((i % span) == 0);
            gran_last[i]  = (((i + 1) % span) == 0);
            gran_live[i]  = packed_mode || (i < span);
        end
    end

endmodule

// File: rtl/lane_addsub_chain.sv
// Module: lane_addsub_chain
// Granule-sliced ripple adder. Subtraction is done as a + ~b + 1. The carry
// into a granule that opens a lane is the operation's own carry-in (sub), so
// no carry or borrow crosses a lane boundary. Exports each granule's carry-out.
// Assumes WORD_W is a whole multiple of GRAN_W.
module lane_addsub_chain #(
    parameter int WORD_W = 64,
    parameter int GRAN_W = 8,
    localparam int NGRAN = WORD_W / GRAN_W
) (
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub,
    input  logic [NGRAN-1:0]  gran_first,
    output logic [WORD_W-1:0] sum,
    output logic [NGRAN-1:0]  gran_cout
);

    logic [NGRAN-1:0] gran_cin;

    for (genvar g = 0; g < NGRAN; g++) begin : g_gran
        logic [GRAN_W:0]   part;
        logic [GRAN_W-1:0] b_eff;

        // Select the granule carry-in: restart at a lane start, else ripple.
        if (g == 0) begin : g_base
            always_comb gran_cin[g] = sub;
        end else begin : g_ripple
            always_comb gran_cin[g] = gran_first[g] ? sub : gran_cout[g-1];
        end

        // Add one granule with the conditionally inverted second operand.
        always_comb begin
            b_eff = op_b[g*GRAN_W +: GRAN_W] ^ {GRAN_W{sub}};
            part  = {1'b0, op_a[g*GRAN_W +: GRAN_W]} + {1'b0, b_eff}
                  + {{GRAN_W{1'b0}}, gran_cin[g]};
            sum[g*GRAN_W +: GRAN_W] = part[GRAN_W-1:0];
            gran_cout[g] = part[GRAN_W];
        end
    end

endmodule

// File: rtl/lane_addsub_flags.sv
// Module: lane_addsub_flags
// Builds the carry word. For each lane, the carry-out of the lane's top
// granule (inverted for subtract, which turns it into a borrow) is placed at
// the lane's least significant bit. All other bits are zero, and the word is
// zero when no second result is requested. Assumes the same granule layout
// as lane_addsub_map.
module lane_addsub_flags
    import lane_addsub_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int GRAN_W = 8,
    localparam int NGRAN = WORD_W / GRAN_W
) (
    input  logic [NGRAN-1:0]  gran_cout,
    input  logic [NGRAN-1:0]  gran_first,
    input  logic [NGRAN-1:0]  gran_live,
    input  logic [1:0]        size_code,
    input  logic              sub,
    input  logic              dual_write,
    output logic [WORD_W-1:0] carry_word
);

    logic [NGRAN-1:0] lane_flag;

    // Fetch, for each lane-opening granule, the carry of the lane's top granule.
    always_comb begin
        int span;
        span = lane_granules(size_code);
        lane_flag = '0;
        for (int i = 0; i < NGRAN; i++) begin
            for (int j = 0; j < NGRAN; j++) begin
                if (j == i + span - 1) begin
                    lane_flag[i] = gran_cout[j] ^ sub;
                end
            end
        end
    end

    // Place each live lane's flag at its lowest bit; clear the rest.
    always_comb begin
        carry_word = '0;
        for (int i = 0; i < NGRAN; i++) begin
            carry_word[i*GRAN_W] = dual_write && gran_live[i] && gran_first[i]
                                   && lane_flag[i];
        end
    end

endmodule

// File: rtl/lane_addsub.sv
// Module: lane_addsub (top)
// Lane-partitioned add/subtract for one 64-bit slice. The lane map, the carry
// chain and the flag builder are combinational. Results, the carry word and
// both destination indices are registered on a sampled in_valid; out_valid
// follows in_valid by one cycle. Assumes rst_n is synchronous and active low,
// and that wider datapaths replicate this slice.
module lane_addsub
    import lane_addsub_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int GRAN_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub,
    input  logic              packed_mode,
    input  logic [1:0]        size_code,
    input  logic              dual_write,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic [WORD_W-1:0] carry_word,
    output logic              out_dual,
    output logic [IDX_W-1:0]  out_dest,
    output logic [IDX_W-1:0]  out_dest2
);

    localparam int NGRAN = WORD_W / GRAN_W;

    logic [NGRAN-1:0]  gran_first;
    logic [NGRAN-1:0]  gran_last;
    logic [NGRAN-1:0]  gran_live;
    logic [NGRAN-1:0]  gran_cout;
    logic [WORD_W-1:0] raw_sum;
    logic [WORD_W-1:0] live_sum;
    logic [WORD_W-1:0] flags_nx;

    lane_addsub_map #(
        .NGRAN (NGRAN)
    ) u_map (
        .size_code   (size_code),
        .packed_mode (packed_mode),
        .gran_first  (gran_first),
        .gran_last   (gran_last),
        .gran_live   (gran_live)
    );

    lane_addsub_chain #(
        .WORD_W (WORD_W),
        .GRAN_W (GRAN_W)
    ) u_chain (
        .op_a       (op_a),
        .op_b       (op_b),
        .sub        (sub),
        .gran_first (gran_first),
        .sum        (raw_sum),
        .gran_cout  (gran_cout)
    );

    lane_addsub_flags #(
        .WORD_W (WORD_W),
        .GRAN_W (GRAN_W)
    ) u_flags (
        .gran_cout  (gran_cout),
        .gran_first (gran_first),
        .gran_live  (gran_live),
        .size_code  (size_code),
        .sub        (sub),
        .dual_write (dual_write),
        .carry_word (flags_nx)
    );

    // Clear granules that lie outside the computed lane (scalar mode).
    always_comb begin
        for (int i = 0; i < NGRAN; i++) begin
            live_sum[i*GRAN_W +: GRAN_W] = gran_live[i] ?
                raw_sum[i*GRAN_W +: GRAN_W] : '0;
        end
    end

    // Valid strobe: one cycle behind the operand strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on a sampled operand strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            carry_word <= '0;
            out_dual   <= 1'b0;
            out_dest   <= '0;
            out_dest2  <= '0;
        end else if (in_valid) begin
            result     <= live_sum;
            carry_word <= flags_nx;
            out_dual   <= dual_write;
            out_dest   <= dest_idx;
            out_dest2  <= {dest_idx[IDX_W-1:1], ~dest_idx[0]};
        end
    end

    // gran_last is part of the map's interface; the flag builder locates lane
    // tops from the size code instead.
    logic unused_last;
    always_comb unused_last = ^gran_last;

endmodule

// File: rtl/lane_addsub_chk.sv
// Module: lane_addsub_chk
// Property checker for lane_addsub, attached by bind below. It checks latency,
// the second index, the carry-word layout, scalar clearing and the full-width
// arithmetic against the sampled port values.
module lane_addsub_chk #(
    parameter int WORD_W = 64,
    parameter int GRAN_W = 8,
    parameter int IDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              sub,
    input logic              packed_mode,
    input logic [1:0]        size_code,
    input logic              dual_write,
    input logic [IDX_W-1:0]  dest_idx,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic [WORD_W-1:0] carry_word,
    input logic              out_dual,
    input logic [IDX_W-1:0]  out_dest,
    input logic [IDX_W-1:0]  out_dest2
);

    // Bits that are not the lowest bit of any granule.
    function automatic logic [WORD_W-1:0] off_gran_mask();
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = ((i % GRAN_W) != 0);
        return m;
    endfunction

    // Bits above the lowest lane of the given size.
    function automatic logic [WORD_W-1:0] above_lane_mask(input logic [1:0] code);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) m[i] = (i >= (GRAN_W << code));
        return m;
    endfunction

    localparam logic [WORD_W-1:0] OFF_GRAN = off_gran_mask();

    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_dest_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_dest2 == {$past(dest_idx[IDX_W-1:1]), ~$past(dest_idx[0])})
                     && (out_dest == $past(dest_idx)));

    assert_no_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dual_write) |=> (carry_word == '0) && !out_dual);

    assert_flag_position_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((carry_word & OFF_GRAN) == '0));

    assert_scalar_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !packed_mode) |=>
            ((result & above_lane_mask($past(size_code))) == '0));

    assert_scalar_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !packed_mode) |=> (carry_word[WORD_W-1:1] == '0));

    assert_full_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'd3) |=>
            (result == ($past(sub) ? $past(op_a) - $past(op_b)
                                   : $past(op_a) + $past(op_b))));

endmodule

bind lane_addsub lane_addsub_chk #(
    .WORD_W (WORD_W),
    .GRAN_W (GRAN_W),
    .IDX_W  (IDX_W)
) u_lane_addsub_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_a        (op_a),
    .op_b        (op_b),
    .sub         (sub),
    .packed_mode (packed_mode),
    .size_code   (size_code),
    .dual_write  (dual_write),
    .dest_idx    (dest_idx),
    .out_valid   (out_valid),
    .result      (result),
    .carry_word  (carry_word),
    .out_dual    (out_dual),
    .out_dest    (out_dest),
    .out_dest2   (out_dest2)
);

// File: tb/test_lane_addsub.sv
// Bench: sweeps every size/mode/operation/dual combination with boundary
// and pseudo-random operands, and compares against a lane-by-lane model.
module test_lane_addsub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        sub = 1'b0;
    logic        packed_mode = 1'b0;
    logic [1:0]  size_code = '0;
    logic        dual_write = 1'b0;
    logic [5:0]  dest_idx = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [63:0] carry_word;
    logic        out_dual;
    logic [5:0]  out_dest;
    logic [5:0]  out_dest2;

    int checks = 0;
    int errors = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    lane_addsub i_lane_addsub (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .op_a (op_a), .op_b (op_b), .sub (sub), .packed_mode (packed_mode),
        .size_code (size_code), .dual_write (dual_write), .dest_idx (dest_idx),
        .out_valid (out_valid), .result (result), .carry_word (carry_word),
        .out_dual (out_dual), .out_dest (out_dest), .out_dest2 (out_dest2)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Lane-by-lane model (R1: width = 8 << size_code).
    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic s,
                         input logic pk, input logic [1:0] sz, input logic dw,
                         output logic [63:0] res, output logic [63:0] cw);
        int w;
        int nl;
        logic [63:0] m;
        w  = 8 << sz;
        nl = pk ? 64 / w : 1;
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        res = '0;
        cw  = '0;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] x;
            logic [63:0] y;
            logic [64:0] t;
            logic c;
            x = (a >> (l * w)) & m;
            y = (b >> (l * w)) & m;
            if (!s) begin
                t = {1'b0, x} + {1'b0, y};
                c = t[w];
            end else begin
                t = {1'b0, x} - {1'b0, y};
                c = (x < y);
            end
            res = res | ((t[63:0] & m) << (l * w));
            if (dw) cw = cw | (64'd1 << (l * w));
            if (dw && !c) cw = cw & ~(64'd1 << (l * w));
        end
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] v);
        return {v[62:0], v[63] ^ v[62] ^ v[60] ^ v[59]};
    endfunction

    // Drive one operation at a falling edge, then check it at the next one.
    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic s,
                          input logic pk, input logic [1:0] sz, input logic dw,
                          input logic [5:0] d);
        logic [63:0] er;
        logic [63:0] ec;
        string rtag;
        string ctag;
        op_a = a; op_b = b; sub = s; packed_mode = pk; size_code = sz;
        dual_write = dw; dest_idx = d; in_valid = 1'b1;
        model(a, b, s, pk, sz, dw, er, ec);
        @(negedge clk);
        rtag = !pk ? "R3 scalar result" : (s ? "R4 packed difference" : "R2 packed sum");
        ctag = !dw ? "R7 carry word off" : (pk ? "R5 packed carry word" : "R6 scalar carry word");
        check64(rtag, result, er);
        check64(ctag, carry_word, ec);
        check64("R8 dest pair / R7 dual / R9 valid",
                {out_valid, out_dual, out_dest, out_dest2},
                {1'b1, dw, d, d ^ 6'd1});
    endtask

    initial begin
        logic [63:0] pa [6];
        logic [63:0] pb [6];
        pa[0] = '1;                    pb[0] = 64'h0101_0101_0101_0101;
        pa[1] = 64'h8080_8080_8080_8080; pb[1] = 64'h8080_8080_8080_8080;
        pa[2] = 64'h0000_0000_0000_0000; pb[2] = 64'h0000_0000_0000_0001;
        pa[3] = 64'h00FF_7FFF_0000_FFFF; pb[3] = 64'h0001_0001_0001_0001;
        pa[4] = 64'h1234_5678_9ABC_DEF0; pb[4] = 64'h1234_5678_9ABC_DEF0;
        pa[5] = 64'h0001_0000_0100_0001; pb[5] = 64'hFFFF_FFFF_FFFF_FFFF;

        // R10: outputs are zero in reset.
        repeat (3) @(negedge clk);
        check64("R10 reset outputs",
                {out_valid, out_dual, out_dest, out_dest2, 50'd0} ^ result ^ carry_word,
                64'd0);
        check64("R10 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep of all configurations (R1 covers every size code).
        for (int cfg = 0; cfg < 32; cfg++) begin
            for (int k = 0; k < 6; k++) begin
                run_op(pa[k], pb[k], cfg[2], cfg[3], cfg[1:0], cfg[4], 6'(cfg + k));
            end
            for (int k = 0; k < 40; k++) begin
                logic [63:0] ra;
                lfsr = next_rand(lfsr);
                ra = lfsr;
                lfsr = next_rand(lfsr);
                run_op(ra, lfsr ^ (ra << 3), cfg[2], cfg[3], cfg[1:0], cfg[4], lfsr[5:0]);
            end
        end

        // R9: no operand strobe leaves valid low and holds the result.
        begin
            logic [63:0] held;
            held = result;
            in_valid = 1'b0;
            op_a = '1;
            @(negedge clk);
            check64("R9 idle valid", {63'd0, out_valid}, 64'd0);
            check64("R9 idle hold", result, held);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule